// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the SCL clock waveform for an I2C master. It sets the low and high halves of each SCL cycle from two programmable 9-bit period counts. Each count has an 8-bit base and a separately supplied top bit. The counts advance on a tick that runs at the module clock rate or at half that rate. A byte engine sits beside the block. It receives a strobe when SCL goes low, which is when the next bit is shifted onto SDA. It receives another strobe when SCL is seen high, which is when SDA is sampled. The engine can also keep SCL low for as long as it needs.

The low half is timed from the first cycle in which the block pulls SCL low. The high half is timed only once the sampled line actually reads high. Rise time and any clock stretching by a slave are therefore added to the high half, and none of that time is taken from it. When a transfer begins, the block first holds SCL released for one high period while the engine holds SDA low. This makes the START hold time equal to the SCL high time. The block then starts the first low phase.

Disabling the block releases SCL at once and clears all of its timing state. A count of zero behaves as a count of one.

Top module: `scl_pacer`

## Requirements
- R1: After reset, and whenever `enable` is 0, `scl_drive_low`, `fall_stb` and `rise_stb` are all 0. A `start_req` pulse seen while `enable` is 0 has no effect.
- R2: A `start_req` accepted while idle and enabled starts a START hold in which SCL stays released. The hold lasts exactly H ticks, where H = {`hi_top`,`hi_base`}. The first low phase follows immediately.
- R3: Each low phase drives SCL low for exactly L ticks, where L = {`lo_top`,`lo_base`}, counted from its first drive cycle. This assumes `hold_low` is 0.
- R4: After SCL is released, high timing starts only once the line has been sensed high through one sampling register. With a slave stretch of S cycles, the released time is 2 + S cycles plus H ticks.
- R5: Counts are 9 bits wide. `lo_top` and `hi_top` supply bit 8, and the base inputs supply bits 7..0. For example, 258 low and 256 high give 258 and 256 ticks.
- R6: When `div2_sel` is 0, one tick equals one clock. When `div2_sel` is 1, one tick equals two clocks, so every phase length doubles exactly.
- R7: A count value of 0 gives a phase of one tick.
- R8: `fall_stb` is 1 for exactly the first cycle of each low phase. `rise_stb` is 1 for exactly the first cycle of counted high time, which is 2 + S cycles after release.
- R9: While `hold_low` is 1, the low phase is extended past its count. When `hold_low` returns to 0, the low phase ends at the clock edge that samples the 0.
- R10: Setting `enable` to 0 during any phase releases SCL on the next cycle. A later START hold is again timed from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; when 0, SCL is released and the timers are cleared |
| start_req | input | 1 | One-cycle request from the byte engine to begin clocking |
| hold_low | input | 1 | Byte engine request to keep SCL low |
| div2_sel | input | 1 | Tick select: 0 = clock rate, 1 = half clock rate |
| lo_base | input | 8 | Low count bits 7..0 |
| lo_top | input | 1 | Low count bit 8 |
| hi_base | input | 8 | High count bits 7..0 |
| hi_top | input | 1 | High count bit 8 |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle of counted high time |

## Verification
Two things can land in the same cycle at the end of a low phase: expiry of the low count, and the byte engine's hold request. The bench provokes this by raising `hold_low` before the low phase begins and dropping it on a chosen cycle well past the count. It then judges the low run length to the exact cycle, so a release that comes one cycle early or one cycle late is caught. A second coincidence is a disable that arrives in the middle of a low phase. The bench checks that the release happens on the next cycle, and that the START hold that follows is timed from zero.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_HOLD = 3'd1,
        PH_LOW  = 3'd2,
        PH_WAIT = 3'd3,
        PH_HIGH = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   drive;
        logic   fall;
        logic   rise;
    } ctl_s;

endpackage

// File: rtl/scl_tick_gen.sv
module scl_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic div2,
    output logic tick
);
    logic pre_d, pre_q;

    always_comb begin
        if (restart || !div2) begin
            pre_d = 1'b0;
        end else begin
            pre_d = ~pre_q;
        end
        tick = !div2 || pre_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= 1'b0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // R6: at half rate, ticks never fall in two cycles in a row
    assert_half_rate_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (div2 && tick && !restart) |=> (!tick || !div2));

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_s;

    tmr_s             t_d, t_q;
    logic [CNT_W-1:0] lim_eff;
    logic             hit;

    always_comb begin
        lim_eff = (limit == '0) ? CNT_W'(1) : limit;
        hit     = tick && !t_q.done && (t_q.cnt == lim_eff - CNT_W'(1));
        last    = t_q.done || hit;
        t_d     = t_q;
        if (clear) begin
            t_d.cnt  = '0;
            t_d.done = 1'b0;
        end else if (!t_q.done && tick) begin
            t_d.cnt = t_q.cnt + CNT_W'(1);
            if (hit) begin
                t_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    // R9: once expired, the count stays frozen until the phase changes
    assert_count_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.done && !clear) |=> (t_q.cnt == $past(t_q.cnt)));

    // R10: a clear always returns the timer to a not-expired state
    assert_clear_rearms_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !t_q.done);

endmodule

// File: rtl/scl_line_sampler.sv
module scl_line_sampler #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = line_in;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], line_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign line_s = sh_q[STAGES-1];

endmodule

// File: rtl/scl_pacer.sv
module scl_pacer #(
    parameter int CNT_W       = 9,
    parameter int SYNC_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start_req,
    input  logic             hold_low,
    input  logic             div2_sel,
    input  logic [CNT_W-2:0] lo_base,
    input  logic             lo_top,
    input  logic [CNT_W-2:0] hi_base,
    input  logic             hi_top,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             fall_stb,
    output logic             rise_stb
);
    import scl_pacer_pkg::*;

    localparam ctl_s CTL_RESET = '{phase: PH_IDLE, drive: 1'b0, fall: 1'b0, rise: 1'b0};

    ctl_s             c_d, c_q;
    logic             tick;
    logic             restart;
    logic             last;
    logic             scl_s;
    logic [CNT_W-1:0] lo_cnt, hi_cnt, limit;

    assign lo_cnt = {lo_top, lo_base};
    assign hi_cnt = {hi_top, hi_base};

    scl_line_sampler #(.STAGES(SYNC_STAGES)) u_samp (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (scl_in),
        .line_s  (scl_s)
    );

    scl_tick_gen u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .div2    (div2_sel),
        .tick    (tick)
    );

    scl_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .tick  (tick),
        .limit (limit),
        .last  (last)
    );

    always_comb begin
        limit  = (c_q.phase == PH_LOW) ? lo_cnt : hi_cnt;
        c_d    = c_q;
        c_d.fall = 1'b0;
        c_d.rise = 1'b0;
        case (c_q.phase)
            PH_IDLE: begin
                if (start_req) begin
                    c_d.phase = PH_HOLD;
                end
            end
            PH_HOLD: begin
                if (last) begin
                    c_d.phase = PH_LOW;
                    c_d.fall  = 1'b1;
                end
            end
            PH_LOW: begin
                if (last && !hold_low) begin
                    c_d.phase = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (scl_s) begin
                    c_d.phase = PH_HIGH;
                    c_d.rise  = 1'b1;
                end
            end
            PH_HIGH: begin
                if (last) begin
                    c_d.phase = PH_LOW;
                    c_d.fall  = 1'b1;
                end
            end
            default: c_d = CTL_RESET;
        endcase
        if (!enable) begin
            c_d = CTL_RESET;
        end
        c_d.drive = (c_d.phase == PH_LOW);
        restart   = (c_d.phase != c_q.phase) || (c_q.phase == PH_IDLE) ||
                    (c_q.phase == PH_WAIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= CTL_RESET;
        end else begin
            c_q <= c_d;
        end
    end

    assign scl_drive_low = c_q.drive;
    assign fall_stb      = c_q.fall;
    assign rise_stb      = c_q.rise;

    // R8: the falling strobe only ever marks a driven-low cycle
    assert_fall_in_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> scl_drive_low);

    // R8: the rising strobe needs a released line that was sensed high
    assert_rise_sensed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (!scl_drive_low && $past(scl_s)));

    // R10: disabling releases SCL and silences the strobes next cycle
    assert_disable_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !fall_stb && !rise_stb));

    // R9: a held low phase stays low while enabled
    assert_hold_keeps_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && scl_drive_low && hold_low) |=> scl_drive_low);

endmodule

// File: tb/sim_scl_pacer.sv
module sim_scl_pacer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       start_req = 1'b0;
    logic       hold_low = 1'b0;
    logic       div2_sel = 1'b0;
    logic [7:0] lo_base = 8'd0;
    logic       lo_top = 1'b0;
    logic [7:0] hi_base = 8'd0;
    logic       hi_top = 1'b0;
    logic       scl_line;
    logic       scl_drive_low, fall_stb, rise_stb;

    int s_cfg = 0;
    int st_cnt = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // open-drain line model with a slave that stretches for s_cfg cycles
    always @(posedge clk) begin
        if (scl_drive_low) st_cnt <= s_cfg;
        else if (st_cnt > 0) st_cnt <= st_cnt - 1;
    end
    assign scl_line = !scl_drive_low && (st_cnt == 0);

    scl_pacer u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_req(start_req),
        .hold_low(hold_low), .div2_sel(div2_sel), .lo_base(lo_base), .lo_top(lo_top),
        .hi_base(hi_base), .hi_top(hi_top), .scl_in(scl_line),
        .scl_drive_low(scl_drive_low), .fall_stb(fall_stb), .rise_stb(rise_stb)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int d2, input int lo, input int hi, input int s);
        div2_sel = d2[0];
        lo_base  = lo[7:0];
        lo_top   = lo[8];
        hi_base  = hi[7:0];
        hi_top   = hi[8];
        s_cfg    = s;
    endtask

    task automatic pulse_start();
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic run_released(output int n, output int ridx);
        n = 0; ridx = -1;
        while (!scl_drive_low) begin
            if (rise_stb) ridx = n;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_low(output int n, output bit fall_ok);
        n = 0; fall_ok = 1'b1;
        while (scl_drive_low) begin
            if ((n == 0) != fall_stb) fall_ok = 1'b0;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic disable_block();
        enable = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int n, ridx, dm, le, he, exp_hi;
        bit fok;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!scl_drive_low && !fall_stb && !rise_stb, "R1 reset outputs",
              {scl_drive_low, fall_stb, rise_stb}, 0);
        // R1: start request ignored while disabled
        set_cfg(0, 3, 3, 0);
        pulse_start();
        repeat (10) begin
            check(!scl_drive_low && !fall_stb, "R1 start while disabled",
                  scl_drive_low, 0);
            @(negedge clk);
        end

        // sweep of tick rate, counts and stretch
        for (int d2 = 0; d2 < 2; d2++) begin
            for (int lo = 0; lo < 4; lo++) begin
                for (int hi = 0; hi < 4; hi++) begin
                    for (int s = 0; s < 3; s++) begin
                        dm = d2 + 1;
                        le = ((lo == 0) ? 1 : lo) * dm;
                        he = ((hi == 0) ? 1 : hi) * dm;
                        set_cfg(d2, lo, hi, s);
                        enable = 1'b1;
                        @(negedge clk);
                        pulse_start();
                        run_released(n, ridx);
                        check(n == he, (hi == 0) ? "R7 start hold zero count" : "R2 start hold",
                              n, he);
                        run_low(n, fok);
                        tag = (lo == 0) ? "R7 low zero count" : (d2 ? "R6 low half rate" : "R3 low length");
                        check(n == le, tag, n, le);
                        check(fok, "R8 fall strobe first low cycle", fok, 1);
                        run_released(n, ridx);
                        exp_hi = 2 + s + he;
                        check(n == exp_hi, (d2 ? "R6 released length" : "R4 released length"),
                              n, exp_hi);
                        check(ridx == 2 + s, "R8 rise strobe position", ridx, 2 + s);
                        run_low(n, fok);
                        check(n == le && fok, "R3 second low length", n, le);
                        disable_block();
                    end
                end
            end
        end

        // R5: ninth bit from the separate top inputs
        set_cfg(0, 258, 256, 0);
        enable = 1'b1;
        @(negedge clk);
        pulse_start();
        run_released(n, ridx);
        check(n == 256, "R5 hold with top bit", n, 256);
        run_low(n, fok);
        check(n == 258, "R5 low with top bit", n, 258);
        run_released(n, ridx);
        check(n == 258, "R5 released with top bit", n, 258);
        disable_block();

        // R9: hold_low extends low; expiry and hold coincide then hold drops
        set_cfg(0, 3, 2, 0);
        hold_low = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        pulse_start();
        run_released(n, ridx);
        n = 0;
        while (scl_drive_low && n < 40) begin
            n++;
            if (n == 40) hold_low = 1'b0;
            @(negedge clk);
        end
        check(scl_drive_low == 1'b0, "R9 release after hold drop", scl_drive_low, 0);
        check(n == 40, "R9 held low length", n, 40);
        run_released(n, ridx);
        run_low(n, fok);
        check(n == 3, "R9 next low normal", n, 3);
        disable_block();

        // R10: disable in mid-low, then a fresh start is timed from zero
        set_cfg(1, 5, 3, 0);
        enable = 1'b1;
        @(negedge clk);
        pulse_start();
        run_released(n, ridx);
        @(negedge clk);
        check(scl_drive_low, "R10 in low before disable", scl_drive_low, 1);
        enable = 1'b0;
        @(negedge clk);
        check(!scl_drive_low, "R10 released after disable", scl_drive_low, 0);
        repeat (2) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        pulse_start();
        run_released(n, ridx);
        check(n == 6, "R10 hold after re-enable", n, 6);
        run_low(n, fok);
        check(n == 10, "R10 low after re-enable", n, 10);
        disable_block();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule